// File: doc/BRIEF.md
# Store-to-Load Forwarding Checker

This block decides, in a single cycle, what happens to a load that is executing. It looks at the stores that are older than the load and still sit in the store queue, starting with the youngest of them. There are four possible outcomes:

- **Forward.** A store whose bytes fully contain the load supplies the data, shifted into place.
- **Replay.** A store that has not yet completed and overlaps only part of the load forces the load to be replayed.
- **Cache access.** If no older store matches, the load goes to the data cache.
- **Reject.** An uncacheable load that is not both at the head of the load queue and ready to commit is rejected for rescheduling.

Each outcome is presented one clock after the load is offered.

The block also keeps two records:

- **Stall record.** It describes the oldest load that was stalled by a partial overlap: the store sequence number, the load sequence number and the load-queue index. The record is dropped when the stalling store reports completion.
- **Blocked record.** It holds the sequence number of the oldest load that found the cache blocked.

The store queue is presented as a snapshot of every slot. The caller supplies the load's store-queue position and the writeback index, which together bound the window that is searched.

Top module: `stl_fwd_unit`

## Requirements
- R1: After reset every outcome output is low, and both the stall record and the blocked record are inactive.
- R2: The searched window is the slots at positions pos−1, pos−2, …, down to and including the writeback index, wrapping modulo SQ_DEPTH. When pos equals the writeback index, no slot is searched and the load goes to the cache path.
- R3: Slots with a size of zero (not yet executed) are skipped. Among the slots that qualify, the youngest one (closest to pos) decides the outcome.
- R4: A store with store_addr ≤ load_addr and load_addr+load_size ≤ store_addr+store_size forwards its data shifted right by ((load_addr & (store_size−1))×8) bits. This happens whether or not the store is complete. fwd_valid rises in the cycle after the load is offered.
- R5: A byte overlap that is not full containment is skipped when the store is complete. Otherwise it produces replay_valid and no forwarded data.
- R6: A replay loads the stall record only if the record is inactive or ld_seq is smaller than the recorded load sequence. A completion report whose sequence equals the recorded store sequence clears the record, unless a replay updates it in the same cycle.
- R7: An uncacheable load that lacks either ld_at_head or ld_at_commit produces only reject_valid. It is not searched and does not touch either record.
- R8: A cache-path load that meets cache_blocked writes its sequence number into the blocked record, unless the record is active and holds a smaller sequence. blk_clear empties the record when no write happens in that cycle.
- R9: A cache-path load with cache_blocked low raises cache_req_valid one cycle later, carrying its address and size. This is at most one cache port per cycle, and the count restarts each cycle.
- R10: Each offered load yields exactly one outcome, tagged with ld_lq_idx on out_lq_idx. A cycle without a load yields none.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_valid | input | 1 | A load is offered this cycle |
| ld_addr | input | ADDR_W | Load byte address |
| ld_size | input | SZ_W | Load size in bytes |
| ld_sq_pos | input | SQ_IDX_W | Store-queue position recorded for the load |
| ld_lq_idx | input | LQ_IDX_W | Load-queue index of the load |
| ld_seq | input | SEQ_W | Load sequence number (smaller is older) |
| ld_uncached | input | 1 | Load is uncacheable |
| ld_at_head | input | 1 | Load is at the load-queue head |
| ld_at_commit | input | 1 | Load is ready to commit |
| sq_wb_idx | input | SQ_IDX_W | Store-queue writeback index |
| sq_addr_flat | input | SQ_DEPTH*ADDR_W | Store addresses, slot i at bits i*ADDR_W |
| sq_size_flat | input | SQ_DEPTH*SZ_W | Store sizes, 0 = not executed |
| sq_data_flat | input | SQ_DEPTH*DATA_W | Store data |
| sq_seq_flat | input | SQ_DEPTH*SEQ_W | Store sequence numbers |
| sq_done | input | SQ_DEPTH | Store has completed, one bit per slot |
| cache_blocked | input | 1 | Data cache cannot accept a request |
| st_cpl_valid | input | 1 | A store completion is reported |
| st_cpl_seq | input | SEQ_W | Sequence number of the completed store |
| blk_clear | input | 1 | Empty the blocked record |
| fwd_valid | output | 1 | Forwarded result valid |
| fwd_data | output | DATA_W | Forwarded data |
| replay_valid | output | 1 | Load must be replayed |
| reject_valid | output | 1 | Uncacheable load rejected |
| cache_req_valid | output | 1 | Request sent to the data cache |
| cache_req_addr | output | ADDR_W | Cache request address |
| cache_req_size | output | SZ_W | Cache request size |
| out_lq_idx | output | LQ_IDX_W | Load-queue index of the outcome |
| stall_active | output | 1 | Stall record valid |
| stall_st_seq | output | SEQ_W | Sequence number of the stalling store |
| stall_ld_seq | output | SEQ_W | Sequence number of the stalled load |
| stall_lq_idx | output | LQ_IDX_W | Load-queue index of the stalled load |
| blk_active | output | 1 | Blocked record valid |
| blk_seq | output | SEQ_W | Sequence number in the blocked record |

## Verification
A wrong window bound or a wrong wrap shows up one cycle later as the wrong outcome kind. For example, a load that should have forwarded goes to the cache instead. A wrong youngest-first priority shows up as forwarded data taken from the wrong slot. A shift error corrupts fwd_data on the first forward at a non-zero offset. Faults in the stall or blocked records appear on their output ports in the cycle after the offending replay or blocked access. They can also stay hidden until a later load with a different age is compared against the bad record.

// File: rtl/stl_fwd_pkg.sv
package stl_fwd_pkg;
  typedef enum logic [2:0] {
    OC_IDLE   = 3'd0,
    OC_REJECT = 3'd1,
    OC_FWD    = 3'd2,
    OC_REPLAY = 3'd3,
    OC_CACHE  = 3'd4
  } outcome_e;
endpackage

// File: rtl/stl_entry_cls.sv
module stl_entry_cls #(
  parameter int ADDR_W = 16,
  parameter int SZ_W   = 4
) (
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic [SZ_W-1:0]   ld_size,
  input  logic [ADDR_W-1:0] st_addr,
  input  logic [SZ_W-1:0]   st_size,
  input  logic              st_done,
  output logic              full_hit,
  output logic              part_live
);
  localparam int EW = ADDR_W + 1;

  function automatic logic [EW-1:0] end_of(input logic [ADDR_W-1:0] a,
                                           input logic [SZ_W-1:0] s);
    return EW'(a) + EW'(s);
  endfunction

  function automatic logic contains(input logic [ADDR_W-1:0] la, input logic [SZ_W-1:0] ls,
                                    input logic [ADDR_W-1:0] sa, input logic [SZ_W-1:0] ss);
    return (la >= sa) && (end_of(la, ls) <= end_of(sa, ss));
  endfunction

  function automatic logic overlaps(input logic [ADDR_W-1:0] la, input logic [SZ_W-1:0] ls,
                                    input logic [ADDR_W-1:0] sa, input logic [SZ_W-1:0] ss);
    return (EW'(la) < end_of(sa, ss)) && (end_of(la, ls) > EW'(sa));
  endfunction

  logic executed;
  assign executed  = (st_size != '0);
  assign full_hit  = executed && contains(ld_addr, ld_size, st_addr, st_size);
  assign part_live = executed && !full_hit && !st_done &&
                     overlaps(ld_addr, ld_size, st_addr, st_size);
endmodule

// File: rtl/stl_youngest_pick.sv
module stl_youngest_pick #(
  parameter int SLOTS = 7,
  localparam int SEL_W = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic [SLOTS-1:0] hit,
  output logic             found,
  output logic [SEL_W-1:0] sel
);
  always_comb begin
    found = 1'b0;
    sel   = '0;
    for (int j = SLOTS - 1; j >= 0; j--) begin
      if (hit[j]) begin
        found = 1'b1;
        sel   = SEL_W'(j);
      end
    end
  end
endmodule

// File: rtl/stl_hold_regs.sv
module stl_hold_regs #(
  parameter int SEQ_W    = 16,
  parameter int LQ_IDX_W = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                partial_evt,
  input  logic [SEQ_W-1:0]    evt_st_seq,
  input  logic [SEQ_W-1:0]    evt_ld_seq,
  input  logic [LQ_IDX_W-1:0] evt_lq_idx,
  input  logic                cpl_valid,
  input  logic [SEQ_W-1:0]    cpl_seq,
  input  logic                blocked_evt,
  input  logic                blk_clear,
  output logic                stall_active,
  output logic [SEQ_W-1:0]    stall_st_seq,
  output logic [SEQ_W-1:0]    stall_ld_seq,
  output logic [LQ_IDX_W-1:0] stall_lq_idx,
  output logic                blk_active,
  output logic [SEQ_W-1:0]    blk_seq
);
  logic stall_take, stall_drop, blk_take;

  assign stall_take = partial_evt && (!stall_active || (evt_ld_seq < stall_ld_seq));
  assign stall_drop = stall_active && cpl_valid && (cpl_seq == stall_st_seq);
  assign blk_take   = blocked_evt && !(blk_active && (blk_seq < evt_ld_seq));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stall_active <= 1'b0;
      stall_st_seq <= '0;
      stall_ld_seq <= '0;
      stall_lq_idx <= '0;
    end else if (stall_take) begin
      stall_active <= 1'b1;
      stall_st_seq <= evt_st_seq;
      stall_ld_seq <= evt_ld_seq;
      stall_lq_idx <= evt_lq_idx;
    end else if (stall_drop) begin
      stall_active <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      blk_active <= 1'b0;
      blk_seq    <= '0;
    end else if (blk_take) begin
      blk_active <= 1'b1;
      blk_seq    <= evt_ld_seq;
    end else if (blk_clear) begin
      blk_active <= 1'b0;
    end
  end

  AST_STALL_OLDER_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (stall_active && $past(stall_active) && (stall_ld_seq != $past(stall_ld_seq)))
      |-> (stall_ld_seq < $past(stall_ld_seq))); // R6

  AST_BLK_OLDEST_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (blk_active && $past(blk_active) && !$past(blk_clear))
      |-> (blk_seq <= $past(blk_seq))); // R8
endmodule

// File: rtl/stl_fwd_unit.sv
module stl_fwd_unit
  import stl_fwd_pkg::*;
#(
  parameter int SQ_DEPTH = 8,
  parameter int ADDR_W   = 16,
  parameter int DATA_W   = 64,
  parameter int SEQ_W    = 16,
  parameter int LQ_IDX_W = 4,
  localparam int SQ_IDX_W = $clog2(SQ_DEPTH),
  localparam int SZ_W     = $clog2(DATA_W / 8) + 1
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         ld_valid,
  input  logic [ADDR_W-1:0]            ld_addr,
  input  logic [SZ_W-1:0]              ld_size,
  input  logic [SQ_IDX_W-1:0]          ld_sq_pos,
  input  logic [LQ_IDX_W-1:0]          ld_lq_idx,
  input  logic [SEQ_W-1:0]             ld_seq,
  input  logic                         ld_uncached,
  input  logic                         ld_at_head,
  input  logic                         ld_at_commit,
  input  logic [SQ_IDX_W-1:0]          sq_wb_idx,
  input  logic [SQ_DEPTH*ADDR_W-1:0]   sq_addr_flat,
  input  logic [SQ_DEPTH*SZ_W-1:0]     sq_size_flat,
  input  logic [SQ_DEPTH*DATA_W-1:0]   sq_data_flat,
  input  logic [SQ_DEPTH*SEQ_W-1:0]    sq_seq_flat,
  input  logic [SQ_DEPTH-1:0]          sq_done,
  input  logic                         cache_blocked,
  input  logic                         st_cpl_valid,
  input  logic [SEQ_W-1:0]             st_cpl_seq,
  input  logic                         blk_clear,
  output logic                         fwd_valid,
  output logic [DATA_W-1:0]            fwd_data,
  output logic                         replay_valid,
  output logic                         reject_valid,
  output logic                         cache_req_valid,
  output logic [ADDR_W-1:0]            cache_req_addr,
  output logic [SZ_W-1:0]              cache_req_size,
  output logic [LQ_IDX_W-1:0]          out_lq_idx,
  output logic                         stall_active,
  output logic [SEQ_W-1:0]             stall_st_seq,
  output logic [SEQ_W-1:0]             stall_ld_seq,
  output logic [LQ_IDX_W-1:0]          stall_lq_idx,
  output logic                         blk_active,
  output logic [SEQ_W-1:0]             blk_seq
);
  localparam int SLOTS = SQ_DEPTH - 1;
  localparam int SEL_W = (SLOTS > 1) ? $clog2(SLOTS) : 1;
  localparam int SH_W  = SZ_W + 3;

  function automatic logic [SH_W-1:0] byte_shift(input logic [ADDR_W-1:0] la,
                                                 input logic [SZ_W-1:0] ss);
    logic [SZ_W-1:0] off;
    off = la[SZ_W-1:0] & (ss - SZ_W'(1));
    return {off, 3'b000};
  endfunction

  // search window: number of slots older than the load, up to writeback index
  logic [SQ_IDX_W-1:0] win_cnt;
  assign win_cnt = ld_sq_pos - sq_wb_idx;

  logic [SQ_IDX_W-1:0] slot_idx  [SLOTS];
  logic [SLOTS-1:0]    slot_full;
  logic [SLOTS-1:0]    slot_part;
  logic [SLOTS-1:0]    slot_hit;

  for (genvar j = 0; j < SLOTS; j++) begin : g_slot
    logic in_win;
    assign slot_idx[j] = ld_sq_pos - SQ_IDX_W'(j + 1);
    assign in_win      = (SQ_IDX_W'(j + 1) <= win_cnt) && (win_cnt != '0);

    stl_entry_cls #(.ADDR_W(ADDR_W), .SZ_W(SZ_W)) u_cls (
      .ld_addr  (ld_addr),
      .ld_size  (ld_size),
      .st_addr  (sq_addr_flat[slot_idx[j]*ADDR_W +: ADDR_W]),
      .st_size  (sq_size_flat[slot_idx[j]*SZ_W +: SZ_W]),
      .st_done  (sq_done[slot_idx[j]]),
      .full_hit (slot_full[j]),
      .part_live(slot_part[j])
    );
    assign slot_hit[j] = in_win && (slot_full[j] || slot_part[j]);
  end

  logic             pick_found;
  logic [SEL_W-1:0] pick_sel;

  stl_youngest_pick #(.SLOTS(SLOTS)) u_pick (
    .hit  (slot_hit),
    .found(pick_found),
    .sel  (pick_sel)
  );

  logic [SQ_IDX_W-1:0] pick_idx;
  logic                pick_full;
  logic [DATA_W-1:0]   pick_data;
  logic [SZ_W-1:0]     pick_size;
  logic [SEQ_W-1:0]    pick_seq;

  assign pick_idx  = slot_idx[pick_sel];
  assign pick_full = slot_full[pick_sel];
  assign pick_data = sq_data_flat[pick_idx*DATA_W +: DATA_W];
  assign pick_size = sq_size_flat[pick_idx*SZ_W +: SZ_W];
  assign pick_seq  = sq_seq_flat[pick_idx*SEQ_W +: SEQ_W];

  outcome_e dec;
  logic     uc_bad;
  assign uc_bad = ld_uncached && !(ld_at_head && ld_at_commit);

  always_comb begin
    dec = OC_IDLE;
    if (ld_valid) begin
      if (uc_bad)                      dec = OC_REJECT;
      else if (pick_found && pick_full) dec = OC_FWD;
      else if (pick_found)             dec = OC_REPLAY;
      else                             dec = OC_CACHE;
    end
  end

  logic partial_evt, blocked_evt;
  assign partial_evt = (dec == OC_REPLAY);
  assign blocked_evt = (dec == OC_CACHE) && cache_blocked;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fwd_valid       <= 1'b0;
      fwd_data        <= '0;
      replay_valid    <= 1'b0;
      reject_valid    <= 1'b0;
      cache_req_valid <= 1'b0;
      cache_req_addr  <= '0;
      cache_req_size  <= '0;
      out_lq_idx      <= '0;
    end else begin
      fwd_valid       <= (dec == OC_FWD);
      replay_valid    <= (dec == OC_REPLAY);
      reject_valid    <= (dec == OC_REJECT);
      cache_req_valid <= (dec == OC_CACHE) && !cache_blocked;
      if (dec == OC_FWD)
        fwd_data <= pick_data >> byte_shift(ld_addr, pick_size);
      if (dec == OC_CACHE) begin
        cache_req_addr <= ld_addr;
        cache_req_size <= ld_size;
      end
      if (ld_valid)
        out_lq_idx <= ld_lq_idx;
    end
  end

  stl_hold_regs #(.SEQ_W(SEQ_W), .LQ_IDX_W(LQ_IDX_W)) u_hold (
    .clk         (clk),
    .rst_n       (rst_n),
    .partial_evt (partial_evt),
    .evt_st_seq  (pick_seq),
    .evt_ld_seq  (ld_seq),
    .evt_lq_idx  (ld_lq_idx),
    .cpl_valid   (st_cpl_valid),
    .cpl_seq     (st_cpl_seq),
    .blocked_evt (blocked_evt),
    .blk_clear   (blk_clear),
    .stall_active(stall_active),
    .stall_st_seq(stall_st_seq),
    .stall_ld_seq(stall_ld_seq),
    .stall_lq_idx(stall_lq_idx),
    .blk_active  (blk_active),
    .blk_seq     (blk_seq)
  );

  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({fwd_valid, replay_valid, reject_valid, cache_req_valid})); // R10

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_valid |=> !(fwd_valid || replay_valid || reject_valid || cache_req_valid)); // R10

  AST_FWD_AFTER_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_valid |-> ($past(ld_valid) && !$past(ld_uncached && !(ld_at_head && ld_at_commit)))); // R4

  AST_REJECT_UNCACHED: assert property (@(posedge clk) disable iff (!rst_n)
    reject_valid |-> $past(ld_uncached)); // R7

  AST_CACHE_UNBLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    cache_req_valid |-> !$past(cache_blocked)); // R9

  AST_EMPTY_WINDOW_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    (win_cnt == '0) |-> !pick_found); // R2
endmodule

// File: tb/stl_fwd_unit_tb_top.sv
module stl_fwd_unit_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int N  = 8;
  localparam int AW = 16;
  localparam int DW = 64;
  localparam int SW = 16;
  localparam int SZW = 4;
  localparam int LW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic ld_valid = 0, ld_uncached = 0, ld_at_head = 0, ld_at_commit = 0;
  logic [AW-1:0] ld_addr = '0;
  logic [SZW-1:0] ld_size = '0;
  logic [2:0] ld_sq_pos = '0, sq_wb_idx = '0;
  logic [LW-1:0] ld_lq_idx = '0;
  logic [SW-1:0] ld_seq = '0, st_cpl_seq = '0;
  logic cache_blocked = 0, st_cpl_valid = 0, blk_clear = 0;

  logic [AW-1:0]  b_addr [N];
  logic [SZW-1:0] b_size [N];
  logic [DW-1:0]  b_data [N];
  logic [SW-1:0]  b_seq  [N];
  logic [N-1:0]   b_done;

  logic [N*AW-1:0] sq_addr_flat;
  logic [N*SZW-1:0] sq_size_flat;
  logic [N*DW-1:0] sq_data_flat;
  logic [N*SW-1:0] sq_seq_flat;
  always_comb begin
    for (int i = 0; i < N; i++) begin
      sq_addr_flat[i*AW +: AW]   = b_addr[i];
      sq_size_flat[i*SZW +: SZW] = b_size[i];
      sq_data_flat[i*DW +: DW]   = b_data[i];
      sq_seq_flat[i*SW +: SW]    = b_seq[i];
    end
  end

  logic fwd_valid, replay_valid, reject_valid, cache_req_valid;
  logic [DW-1:0] fwd_data;
  logic [AW-1:0] cache_req_addr;
  logic [SZW-1:0] cache_req_size;
  logic [LW-1:0] out_lq_idx, stall_lq_idx;
  logic stall_active, blk_active;
  logic [SW-1:0] stall_st_seq, stall_ld_seq, blk_seq;

  stl_fwd_unit dut_i (
    .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_addr(ld_addr), .ld_size(ld_size),
    .ld_sq_pos(ld_sq_pos), .ld_lq_idx(ld_lq_idx), .ld_seq(ld_seq), .ld_uncached(ld_uncached),
    .ld_at_head(ld_at_head), .ld_at_commit(ld_at_commit), .sq_wb_idx(sq_wb_idx),
    .sq_addr_flat(sq_addr_flat), .sq_size_flat(sq_size_flat), .sq_data_flat(sq_data_flat),
    .sq_seq_flat(sq_seq_flat), .sq_done(b_done), .cache_blocked(cache_blocked),
    .st_cpl_valid(st_cpl_valid), .st_cpl_seq(st_cpl_seq), .blk_clear(blk_clear),
    .fwd_valid(fwd_valid), .fwd_data(fwd_data), .replay_valid(replay_valid),
    .reject_valid(reject_valid), .cache_req_valid(cache_req_valid),
    .cache_req_addr(cache_req_addr), .cache_req_size(cache_req_size), .out_lq_idx(out_lq_idx),
    .stall_active(stall_active), .stall_st_seq(stall_st_seq), .stall_ld_seq(stall_ld_seq),
    .stall_lq_idx(stall_lq_idx), .blk_active(blk_active), .blk_seq(blk_seq)
  );

  int n_checks = 0, n_fail = 0, cyc = 0;
  bit done_flag = 0;

  // model state
  bit m_st_act = 0, m_blk_act = 0;
  logic [SW-1:0] m_st_sseq = '0, m_st_lseq = '0, m_blk_seq = '0;
  logic [LW-1:0] m_st_lq = '0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // kind: 0 idle, 1 reject, 2 forward, 3 replay, 4 cache
  task automatic decide(output int kind, output int pidx);
    int i;
    longint la, le, sa, se;
    kind = 0; pidx = 0;
    if (!ld_valid) return;
    if (ld_uncached && !(ld_at_head && ld_at_commit)) begin kind = 1; return; end
    i = ld_sq_pos;
    while (i != sq_wb_idx) begin
      i = (i + N - 1) % N;
      if (b_size[i] == 0) continue;
      la = ld_addr; le = la + ld_size; sa = b_addr[i]; se = sa + b_size[i];
      if (la >= sa && le <= se) begin kind = 2; pidx = i; return; end
      if (la < se && le > sa) begin
        if (b_done[i]) continue;
        kind = 3; pidx = i; return;
      end
    end
    kind = 4;
  endtask

  task automatic step();
    int kind, pidx;
    logic [63:0] exp_data;
    bit n_st_act, n_blk_act;
    logic [SW-1:0] n_sseq, n_lseq, n_bseq;
    logic [LW-1:0] n_lq;
    decide(kind, pidx);
    exp_data = (kind == 2) ? (b_data[pidx] >> ((ld_addr & (b_size[pidx] - 1)) * 8)) : 64'd0;
    n_st_act = m_st_act; n_sseq = m_st_sseq; n_lseq = m_st_lseq; n_lq = m_st_lq;
    if (kind == 3 && (!m_st_act || ld_seq < m_st_lseq)) begin
      n_st_act = 1; n_sseq = b_seq[pidx]; n_lseq = ld_seq; n_lq = ld_lq_idx;
    end else if (m_st_act && st_cpl_valid && st_cpl_seq == m_st_sseq) n_st_act = 0;
    n_blk_act = m_blk_act; n_bseq = m_blk_seq;
    if (kind == 4 && cache_blocked && !(m_blk_act && m_blk_seq < ld_seq)) begin
      n_blk_act = 1; n_bseq = ld_seq;
    end else if (blk_clear) n_blk_act = 0;
    @(posedge clk); #1;
    cyc++;
    chk(fwd_valid == (kind == 2), "R4 fwd_valid", 64'(fwd_valid), 64'(kind == 2));
    if (kind == 2) chk(fwd_data == exp_data, "R4/R3/R2 fwd_data", fwd_data, exp_data);
    chk(replay_valid == (kind == 3), "R5 replay_valid", 64'(replay_valid), 64'(kind == 3));
    chk(reject_valid == (kind == 1), "R7 reject_valid", 64'(reject_valid), 64'(kind == 1));
    chk(cache_req_valid == (kind == 4 && !cache_blocked), "R9 cache_req_valid",
        64'(cache_req_valid), 64'(kind == 4 && !cache_blocked));
    if (kind == 4 && !cache_blocked)
      chk({cache_req_addr, cache_req_size} == {ld_addr, ld_size}, "R9 cache_req_addr/size",
          64'({cache_req_addr, cache_req_size}), 64'({ld_addr, ld_size}));
    if (kind != 0) chk(out_lq_idx == ld_lq_idx, "R10 out_lq_idx", 64'(out_lq_idx), 64'(ld_lq_idx));
    chk(stall_active == n_st_act, "R6 stall_active", 64'(stall_active), 64'(n_st_act));
    if (n_st_act)
      chk({stall_st_seq, stall_ld_seq, stall_lq_idx} == {n_sseq, n_lseq, n_lq}, "R6 stall record",
          64'({stall_st_seq, stall_ld_seq, stall_lq_idx}), 64'({n_sseq, n_lseq, n_lq}));
    chk(blk_active == n_blk_act, "R8 blk_active", 64'(blk_active), 64'(n_blk_act));
    if (n_blk_act) chk(blk_seq == n_bseq, "R8 blk_seq", 64'(blk_seq), 64'(n_bseq));
    m_st_act = n_st_act; m_st_sseq = n_sseq; m_st_lseq = n_lseq; m_st_lq = n_lq;
    m_blk_act = n_blk_act; m_blk_seq = n_bseq;
    @(negedge clk);
  endtask

  function automatic logic [SZW-1:0] pick_size(input int r, input bit allow_zero);
    int k = allow_zero ? (r % 5) : (r % 4 + 1);
    case (k)
      0: return 4'd0;
      1: return 4'd1;
      2: return 4'd2;
      3: return 4'd4;
      default: return 4'd8;
    endcase
  endfunction

  task automatic clear_queue();
    for (int i = 0; i < N; i++) begin
      b_addr[i] = '0; b_size[i] = '0; b_data[i] = '0; b_seq[i] = SW'(i + 1);
    end
    b_done = '0;
  endtask

  task automatic plain_load(input logic [AW-1:0] a, input logic [SZW-1:0] s,
                            input logic [2:0] pos, input logic [2:0] wb);
    ld_valid = 1; ld_addr = a; ld_size = s; ld_sq_pos = pos; sq_wb_idx = wb;
    ld_uncached = 0; ld_at_head = 0; ld_at_commit = 0; cache_blocked = 0;
    st_cpl_valid = 0; blk_clear = 0; ld_lq_idx = LW'(pos); ld_seq = 16'd100;
  endtask

  always @(posedge clk) begin
    if (cyc > 100000 && !done_flag) begin
      done_flag = 1;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    clear_queue();
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    #1;
    // R1: reset state
    chk(!(fwd_valid || replay_valid || reject_valid || cache_req_valid), "R1 outcomes after reset",
        64'({fwd_valid, replay_valid, reject_valid, cache_req_valid}), 64'd0);
    chk(!stall_active && !blk_active, "R1 records after reset", 64'({stall_active, blk_active}), 64'd0);
    @(negedge clk);

    // R2: empty window although slot 2 fully covers
    clear_queue(); b_addr[2] = 16'h10; b_size[2] = 8; b_data[2] = 64'h1122334455667788;
    plain_load(16'h10, 4, 3'd3, 3'd3); step();
    // R2: wrap-around window reaches slot 7 (pos 1, wb 6)
    clear_queue(); b_addr[7] = 16'h20; b_size[7] = 8; b_data[7] = 64'hA1B2C3D4E5F60718;
    plain_load(16'h24, 2, 3'd1, 3'd6); step();
    // R3: younger zero-size slot skipped, older full covers with shift
    clear_queue(); b_addr[4] = 16'h24; b_size[4] = 0; b_addr[3] = 16'h20; b_size[3] = 8;
    b_data[3] = 64'h0102030405060708;
    plain_load(16'h26, 1, 3'd5, 3'd0); step();
    // R5: completed partial skipped, older full forwards
    clear_queue(); b_addr[4] = 16'h22; b_size[4] = 2; b_done[4] = 1;
    b_addr[2] = 16'h20; b_size[2] = 4; b_data[2] = 64'hDEADBEEF;
    plain_load(16'h20, 4, 3'd5, 3'd1); step();
    // R5: same overlap but not completed -> replay, R6 record taken
    b_done[4] = 0; step();
    // R6: older load replays against slot 4 -> record updated; younger does not
    ld_seq = 16'd50; step();
    ld_seq = 16'd70; step();
    // R6: completion of stalling store clears record
    ld_valid = 0; st_cpl_valid = 1; st_cpl_seq = b_seq[4]; step();
    // R7: uncached not at commit rejected
    clear_queue(); plain_load(16'h40, 8, 3'd2, 3'd0); ld_uncached = 1; ld_at_head = 1; step();
    ld_at_commit = 1; step();
    // R8: blocked records older only
    plain_load(16'h40, 8, 3'd2, 3'd0); cache_blocked = 1; ld_seq = 16'd30; step();
    ld_seq = 16'd40; step();
    ld_seq = 16'd20; step();
    ld_valid = 0; blk_clear = 1; step();

    // constrained random
    for (int v = 0; v < 3000; v++) begin
      for (int i = 0; i < N; i++) begin
        b_size[i] = pick_size($urandom, 1);
        b_addr[i] = AW'($urandom % 32) & ~AW'((b_size[i] == 0) ? 0 : b_size[i] - 1);
        b_data[i] = {$urandom, $urandom};
        b_seq[i]  = SW'($urandom % 200);
        b_done[i] = ($urandom % 3) == 0;
      end
      ld_valid = ($urandom % 10) != 0;
      ld_size = pick_size($urandom, 0);
      ld_addr = AW'($urandom % 32) & ~AW'(ld_size - 1);
      ld_sq_pos = 3'($urandom); sq_wb_idx = 3'($urandom);
      ld_lq_idx = LW'($urandom); ld_seq = SW'($urandom % 200);
      ld_uncached = ($urandom % 10) == 0;
      ld_at_head = $urandom % 2; ld_at_commit = $urandom % 2;
      cache_blocked = ($urandom % 5) == 0;
      st_cpl_valid = ($urandom % 3) == 0;
      st_cpl_seq = (($urandom % 2) == 0) ? m_st_sseq : SW'($urandom % 200);
      blk_clear = ($urandom % 10) == 0;
      step();
    end

    if (!done_flag) begin
      done_flag = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end
endmodule